// File: doc/BRIEF.md
# Output Port Set/Reset Register

This block holds an 8-bit general-purpose output register that software never writes directly. Two command codes change it bit by bit. One command raises the register bits marked by ones in the accompanying data word. The other command lowers the marked bits. Every unmarked bit keeps its value. A pin that shows the register drives the inverse of the stored bit, so a cleared register leaves those pins high.

Each pin can show either its register bit or an alternate internal signal. For pins 2 to 7, a six-bit source-select register holds one bit per pin. Pins 0 and 1 ignore that register and follow a separate two-bit mode input. A typical use routes an interrupt or transmitter-ready flag to pin 6 or pin 7.

Commands arrive as a one-cycle strobe with a 4-bit code and an 8-bit data word. The source-select register is loaded by its own strobe from the same data word.

Top module: `opsr_top`

## Requirements
- R1: After a synchronous active-low reset, the output register and the source-select register are both zero. Every pin that shows its register bit is therefore high.
- R2: A strobe with code 0xE sets each output register bit whose data bit is one. The change is visible on the pins right after the accepting clock edge.
- R3: A strobe with code 0xF clears each output register bit whose data bit is one. The change is visible on the pins right after the accepting clock edge.
- R4: Any register bit whose data bit is zero keeps its value. A strobe with any other code, or data presented without the strobe, leaves the register unchanged.
- R5: A pin that shows its register bit drives the logical inverse of that bit: a stored one gives a low pin.
- R6: For pin i in 2..7, source-select bit i-2 chooses the source: one selects alternate input bit i, unmodified, and zero selects the inverted register bit.
- R7: Pins 0 and 1 are chosen by mode bits 0 and 1: one selects the alternate input and zero selects the inverted register bit. The source-select register has no effect on these pins.
- R8: The source-select strobe loads data bits 7..2 into source-select bits 5..0 at the next clock edge. Data bits 1..0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 4 | Command code (0xE set, 0xF clear) |
| cmd_data | input | 8 | Bit mask for commands; source-select data on bits 7..2 |
| sel_wr | input | 1 | Load strobe for the source-select register |
| low_mode | input | 2 | Source choice for pins 1..0 |
| alt_in | input | 8 | Alternate signal for each pin |
| pin_out | output | 8 | Output pins |

## Verification
The assertions assume that at most one command is presented per cycle, so a same-cycle collision of set and clear cannot occur. They also assume that the inputs are stable at each rising edge. The bench keeps within this by changing every input on the falling edge and issuing a single code per cycle. Random cycles draw codes from a pool weighted toward 0xE and 0xF but still include other codes and idle strobes. Directed cases cover empty masks, full masks, a foreign code and a reset in mid-run.

// File: rtl/opsr_pkg.sv
// Shared constants for the output port set/reset register.
// Assumes a 4-bit command code field.
package opsr_pkg;
    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] CODE_SET = 4'hE;
    localparam logic [CODE_W-1:0] CODE_CLR = 4'hF;
endpackage

// File: rtl/opsr_bitreg.sv
// Output register changed only by bitwise set and clear commands.
// Assumes at most one command per cycle; synchronous active-low reset.
module opsr_bitreg
    import opsr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [W-1:0]      cmd_data,
    output logic [W-1:0]      reg_q
);
    logic do_set;
    logic do_clr;

    // Decode the two commands that act on the register.
    always_comb begin
        do_set = cmd_valid && (cmd_code == CODE_SET);
        do_clr = cmd_valid && (cmd_code == CODE_CLR);
    end

    // Apply the masked set or clear on the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '0;
        else if (do_set)
            reg_q <= reg_q | cmd_data;
        else if (do_clr)
            reg_q <= reg_q & ~cmd_data;
    end

    p_reset_r1: assert property (@(posedge clk) !rst_n |=> reg_q == '0);
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CODE_SET) |=> ((reg_q & $past(cmd_data)) == $past(cmd_data)));
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CODE_CLR) |=> ((reg_q & $past(cmd_data)) == '0));
    p_unmarked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> ((reg_q & ~$past(cmd_data)) == ($past(reg_q) & ~$past(cmd_data))));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && (cmd_code == CODE_SET || cmd_code == CODE_CLR)) |=> $stable(reg_q));
endmodule

// File: rtl/opsr_srcmux.sv
// Holds the source-select register and chooses the source for each pin:
// the inverted register bit or an alternate signal. Pins below NLOW follow
// low_mode; the others follow the source-select register.
module opsr_srcmux #(
    parameter int W    = 8,
    parameter int NLOW = 2,
    localparam int NSEL = W - NLOW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_wr,
    input  logic [NSEL-1:0] sel_data,
    input  logic [NLOW-1:0] low_mode,
    input  logic [W-1:0]    reg_q,
    input  logic [W-1:0]    alt_in,
    output logic [W-1:0]    pin_out
);
    logic [NSEL-1:0] sel_q;

    // Load the per-pin source choice.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (sel_wr)
            sel_q <= sel_data;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic use_alt;
        if (i < NLOW) begin : g_low
            // Low pins: source from the mode input.
            always_comb use_alt = low_mode[i];
        end else begin : g_sel
            // Upper pins: source from the select register.
            always_comb use_alt = sel_q[i-NLOW];
        end
        // Drive the pin from the chosen source.
        always_comb pin_out[i] = use_alt ? alt_in[i] : ~reg_q[i];
    end

    p_sel_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> sel_q == $past(sel_data));
    p_sel_reset_r1: assert property (@(posedge clk) !rst_n |=> sel_q == '0);
endmodule

// File: rtl/opsr_top.sv
// Output port set/reset register top: a masked set/clear output register
// followed by the per-pin source multiplexer.
// Assumes at most one command per cycle and inputs stable at each edge.
module opsr_top
    import opsr_pkg::*;
#(
    parameter int W    = 8,
    parameter int NLOW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [W-1:0]      cmd_data,
    input  logic              sel_wr,
    input  logic [NLOW-1:0]   low_mode,
    input  logic [W-1:0]      alt_in,
    output logic [W-1:0]      pin_out
);
    logic [W-1:0] reg_q;

    opsr_bitreg #(.W(W)) u_reg (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_data(cmd_data), .reg_q(reg_q)
    );

    opsr_srcmux #(.W(W), .NLOW(NLOW)) u_mux (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr),
        .sel_data(cmd_data[W-1:NLOW]), .low_mode(low_mode),
        .reg_q(reg_q), .alt_in(alt_in), .pin_out(pin_out)
    );

    // A top pin shown from the register goes low once its bit is set.
    p_pin_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CODE_SET && cmd_data[W-1] && !sel_wr
         && $past(sel_wr) == 1'b0 && u_mux.sel_q[W-NLOW-1] == 1'b0)
        |=> !pin_out[W-1]);
endmodule

// File: tb/opsr_top_tb_top.sv
// Bench: directed corners plus seeded random commands against a bench model.
module opsr_top_tb_top;
    logic       clk = 0;
    logic       rst_n;
    logic       cmd_valid;
    logic [3:0] cmd_code;
    logic [7:0] cmd_data;
    logic       sel_wr;
    logic [1:0] low_mode;
    logic [7:0] alt_in;
    logic [7:0] pin_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_reg;
    logic [5:0] m_sel;

    always #10 clk = ~clk;

    opsr_top dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_data(cmd_data), .sel_wr(sel_wr), .low_mode(low_mode),
        .alt_in(alt_in), .pin_out(pin_out)
    );

    function automatic logic [7:0] exp_pins(logic [7:0] r, logic [5:0] s,
                                            logic [1:0] lm, logic [7:0] a);
        logic [7:0] e;
        for (int i = 0; i < 8; i++) begin
            logic ua;
            ua = (i < 2) ? lm[i] : s[i-2];
            e[i] = ua ? a[i] : ~r[i];
        end
        return e;
    endfunction

    task automatic check(string req, logic [7:0] exp);
        checks++;
        if (pin_out !== exp) begin
            errors++;
            $display("FAIL %s pins=%h expected=%h", req, pin_out, exp);
        end
    endtask

    // One cycle: drive at falling edge, update model at rising edge, check after.
    task automatic step(logic v, logic [3:0] c, logic [7:0] d, logic sw,
                        logic [1:0] lm, logic [7:0] a, logic rn, string req);
        @(negedge clk);
        cmd_valid = v; cmd_code = c; cmd_data = d; sel_wr = sw;
        low_mode = lm; alt_in = a; rst_n = rn;
        @(posedge clk);
        if (!rn) begin
            m_reg = 0; m_sel = 0;
        end else begin
            if (v && c == 4'hE) m_reg = m_reg | d;
            else if (v && c == 4'hF) m_reg = m_reg & ~d;
            if (sw) m_sel = d[7:2];
        end
        #5;
        check(req, exp_pins(m_reg, m_sel, lm, a));
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_reg = 0; m_sel = 0;
        rst_n = 0; cmd_valid = 0; cmd_code = 0; cmd_data = 0;
        sel_wr = 0; low_mode = 0; alt_in = 0;
        step(0, 0, 0, 0, 0, 8'h00, 0, "R1");
        step(0, 0, 0, 0, 0, 8'h00, 1, "R1");
        if (pin_out !== 8'hFF) begin
            errors++; $display("FAIL R1 pins=%h expected=ff", pin_out);
        end
        checks++;
        step(1, 4'hE, 8'h21, 0, 0, 8'h00, 1, "R2");
        step(1, 4'hE, 8'h02, 0, 0, 8'h00, 1, "R2");
        step(1, 4'hF, 8'h01, 0, 0, 8'h00, 1, "R3");
        step(1, 4'hF, 8'h00, 0, 0, 8'h00, 1, "R4");
        step(1, 4'h3, 8'hFF, 0, 0, 8'h00, 1, "R4");
        step(0, 4'hE, 8'hFF, 0, 0, 8'h00, 1, "R4");
        step(1, 4'hE, 8'h80, 0, 0, 8'h00, 1, "R5");
        step(0, 0, 8'hC3, 1, 0, 8'h40, 1, "R8");
        step(0, 0, 8'h00, 0, 0, 8'hBF, 1, "R6");
        step(0, 0, 8'h00, 0, 2'b01, 8'h01, 1, "R7");
        step(0, 0, 8'h00, 0, 2'b10, 8'h00, 1, "R7");
        step(1, 4'hE, 8'hFF, 0, 0, 8'h00, 1, "R2");
        step(1, 4'hF, 8'hFF, 0, 0, 8'h00, 1, "R3");
        for (int n = 0; n < 400; n++) begin
            logic [3:0] c;
            logic rn;
            int pick;
            pick = $urandom_range(0, 9);
            c = (pick < 4) ? 4'hE : (pick < 8) ? 4'hF : 4'($urandom);
            rn = ($urandom_range(0, 99) != 0);
            step(1'($urandom), c, 8'($urandom), ($urandom_range(0, 7) == 0),
                 2'($urandom), 8'($urandom), rn, "R2 R3 R4 R6 R7");
        end
        step(0, 0, 0, 0, 0, 8'h00, 0, "R1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule